// File: doc/BRIEF.md
# Halfword and Signed-Byte Load/Store Address Unit

This unit handles the narrow transfers of a 32-bit core: unsigned halfword loads, signed byte loads, signed halfword loads and halfword/byte stores. It accepts one already-fetched 32-bit instruction word together with the base register value, the offset register value and the low half of the store data register. From these it works out the memory address and the base writeback value, then issues one memory request.

The offset is either an 8-bit constant or the full offset register. The constant is split into two nibbles that sit on either side of the transfer code. The offset is added or subtracted, and it is applied before the access (pre-indexed) or after it (post-indexed). When the memory response arrives, the unit presents two register-write ports in that same cycle. One carries the extended load result for the destination register. The other carries the updated base value.

A faulting response cancels both register writes and raises an abort pulse instead. The register file, the memory system and exception vectoring are outside this block.

Top module: `lsx_ls_unit`

## Requirements
- R1: Transfer code `instr[7:4]`: 4'b1011 = unsigned halfword, 4'b1101 = signed byte, 4'b1111 = signed halfword. `mem_size` is 0 for the byte code and 1 for the halfword codes.
- R2: When `instr[22]` = 1 the offset is `{instr[11:8], instr[3:0]}`, zero-extended to 32 bits.
- R3: When `instr[22]` = 0 the offset is the full 32-bit `ofs_val`, and `instr[11:8]` has no effect.
- R4: When `instr[24]` = 0 (post-indexed), `mem_addr` is the unmodified base. The base writeback always happens, with base ± offset, whatever `instr[21]` holds.
- R5: When `instr[24]` = 1 (pre-indexed), `mem_addr` is base ± offset. That same value is written back to the base only when `instr[21]` = 1.
- R6: `instr[23]` = 1 adds the offset and `instr[23]` = 0 subtracts it, modulo 2^32.
- R7: The load result is sign-extended from bit 7 for the signed-byte code and from bit 15 for the signed-halfword code. It is zero-extended for the unsigned-halfword code. `rd_idx` = `instr[15:12]` and `wb_idx` = `instr[19:16]`.
- R8: A response with `mem_fault` = 1 raises `abort` for that cycle and keeps both `rd_we` and `wb_we` low.
- R9: When `instr[20]` = 0 (store), `mem_we` = 1 and `mem_wdata` = `store_half`. There is no destination write; the base writeback follows R4/R5.
- R10: `mem_req_valid` rises in the cycle after a request is accepted. It holds with a stable address, size and data until `mem_rsp_valid`. The register writes and `abort` appear in the response cycle, and the unit is idle in the next cycle.
- R11: `req_valid` is ignored while a request is outstanding.
- R12: After reset, `mem_req_valid`, `rd_we`, `wb_we` and `abort` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | New operation offered (taken only when idle) |
| instr | input | 32 | Instruction word |
| base_val | input | 32 | Base register value |
| ofs_val | input | 32 | Offset register value |
| store_half | input | 16 | Low half of the data register for stores |
| mem_req_valid | output | 1 | Memory request outstanding |
| mem_addr | output | 32 | Memory address |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_size | output | 1 | 0 = byte, 1 = halfword |
| mem_wdata | output | 16 | Store data |
| mem_rsp_valid | input | 1 | Memory response |
| mem_rdata | input | 16 | Load data, right-aligned |
| mem_fault | input | 1 | Response is a fault |
| rd_we | output | 1 | Destination register write enable |
| rd_idx | output | 4 | Destination register index |
| rd_data | output | 32 | Extended load result |
| wb_we | output | 1 | Base register write enable |
| wb_idx | output | 4 | Base register index |
| wb_data | output | 32 | Updated base value |
| abort | output | 1 | Data abort pulse |

## Verification
A wrong captured address, direction or indexing choice shows on `mem_addr` one cycle after acceptance. That is before any response is needed, so the bench compares it there. A wrong writeback enable, extension or fault gating shows on the register-write ports in the response cycle itself. A stuck busy state shows the cycle after the response, either as `mem_req_valid` staying high or as a stray request picked up from `req_valid` held during a stall.

// File: rtl/lsx_pkg.sv
// Shared types for the narrow load/store address unit.
// Assumes the instruction field positions listed in the brief.
package lsx_pkg;

    typedef enum logic [1:0] {
        XF_UHALF = 2'd0,
        XF_SBYTE = 2'd1,
        XF_SHALF = 2'd2
    } xfer_e;

    typedef struct packed {
        logic       pre;
        logic       up;
        logic       imm;
        logic       wbit;
        logic       load;
        logic [3:0] base_idx;
        logic [3:0] dst_idx;
        logic [7:0] imm_ofs;
        xfer_e      kind;
    } dec_t;

endpackage

// File: rtl/lsx_decode.sv
// Field decoder: splits the instruction word into control bits, register
// indices, the two-nibble constant offset and the transfer kind.
// Assumes a purely combinational use; unknown codes fall back to unsigned half.
module lsx_decode
    import lsx_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    logic unused_bits;

    // gather the bits the unit never reads
    assign unused_bits = ^instr[31:25];

    // split fields and classify the transfer code
    always_comb begin
        dec.pre      = instr[24];
        dec.up       = instr[23];
        dec.imm      = instr[22];
        dec.wbit     = instr[21];
        dec.load     = instr[20];
        dec.base_idx = instr[19:16];
        dec.dst_idx  = instr[15:12];
        dec.imm_ofs  = {instr[11:8], instr[3:0]};
        case (instr[7:4])
            4'b1101: dec.kind = XF_SBYTE;
            4'b1111: dec.kind = XF_SHALF;
            default: dec.kind = XF_UHALF;
        endcase
    end
endmodule

// File: rtl/lsx_addr_gen.sv
// Address generator: picks the offset source, adds or subtracts it, and
// chooses pre- or post-indexed addressing. Purely combinational.
module lsx_addr_gen #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 8
) (
    input  logic [XLEN-1:0]  base,
    input  logic [XLEN-1:0]  reg_ofs,
    input  logic [IMM_W-1:0] imm_ofs,
    input  logic             use_imm,
    input  logic             up,
    input  logic             pre,
    output logic [XLEN-1:0]  addr,
    output logic [XLEN-1:0]  sum
);
    localparam int PAD_W = XLEN - IMM_W;

    logic [XLEN-1:0] ofs;

    // select the offset source
    always_comb ofs = use_imm ? {{PAD_W{1'b0}}, imm_ofs} : reg_ofs;

    // apply the direction and the indexing mode
    always_comb begin
        sum  = up ? (base + ofs) : (base - ofs);
        addr = pre ? sum : base;
    end
endmodule

// File: rtl/lsx_extend.sv
// Load result extender: widens right-aligned memory data by transfer kind.
module lsx_extend
    import lsx_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  xfer_e            kind,
    input  logic [15:0]      raw,
    output logic [XLEN-1:0]  ext
);
    localparam int HI_B = XLEN - 8;
    localparam int HI_H = XLEN - 16;

    // sign- or zero-extend the loaded value
    always_comb begin
        case (kind)
            XF_SBYTE: ext = {{HI_B{raw[7]}}, raw[7:0]};
            XF_SHALF: ext = {{HI_H{raw[15]}}, raw};
            default:  ext = {{HI_H{1'b0}}, raw};
        endcase
    end
endmodule

// File: rtl/lsx_ctrl.sv
// Request controller: captures one operation when idle, holds the memory
// request until a response, then gates the two register writes and abort.
// Assumes the memory side holds mem_rsp_valid for one cycle per request.
module lsx_ctrl
    import lsx_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  dec_t             dec,
    input  logic [XLEN-1:0]  addr_in,
    input  logic [XLEN-1:0]  sum_in,
    input  logic [15:0]      wdata_in,
    input  logic             mem_rsp_valid,
    input  logic             mem_fault,
    input  logic [XLEN-1:0]  ext_data,
    output xfer_e            kind_q,
    output logic             mem_req_valid,
    output logic [XLEN-1:0]  mem_addr,
    output logic             mem_we,
    output logic             mem_size,
    output logic [15:0]      mem_wdata,
    output logic             rd_we,
    output logic [IDX_W-1:0] rd_idx,
    output logic [XLEN-1:0]  rd_data,
    output logic             wb_we,
    output logic [IDX_W-1:0] wb_idx,
    output logic [XLEN-1:0]  wb_data,
    output logic             abort
);
    logic             busy_q;
    logic             accept;
    logic             finish;
    logic             good;
    logic [XLEN-1:0]  addr_q;
    logic [XLEN-1:0]  sum_q;
    logic             wb_en_q;
    logic             load_q;
    logic [IDX_W-1:0] dst_q;
    logic [IDX_W-1:0] base_q;
    logic [15:0]      wdata_q;

    // handshake terms for this cycle
    always_comb begin
        accept = req_valid & ~busy_q;
        finish = busy_q & mem_rsp_valid;
        good   = finish & ~mem_fault;
    end

    // busy flag: set on accept, cleared on response
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_q <= 1'b0;
        else if (accept) busy_q <= 1'b1;
        else if (finish) busy_q <= 1'b0;
    end

    // operation capture register, loaded only on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            sum_q   <= '0;
            wb_en_q <= 1'b0;
            load_q  <= 1'b0;
            kind_q  <= XF_UHALF;
            dst_q   <= '0;
            base_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= addr_in;
            sum_q   <= sum_in;
            wb_en_q <= ~dec.pre | dec.wbit;
            load_q  <= dec.load;
            kind_q  <= dec.kind;
            dst_q   <= dec.dst_idx;
            base_q  <= dec.base_idx;
            wdata_q <= wdata_in;
        end
    end

    // memory request side
    always_comb begin
        mem_req_valid = busy_q;
        mem_addr      = addr_q;
        mem_we        = ~load_q;
        mem_size      = (kind_q != XF_SBYTE);
        mem_wdata     = wdata_q;
    end

    // register write ports and abort, valid in the response cycle
    always_comb begin
        rd_we   = good & load_q;
        rd_idx  = dst_q;
        rd_data = ext_data;
        wb_we   = good & wb_en_q;
        wb_idx  = base_q;
        wb_data = sum_q;
        abort   = finish & mem_fault;
    end
endmodule

// File: rtl/lsx_ls_unit.sv
// Top of the narrow load/store address unit: decode, address generation,
// request control and load extension. One operation in flight at a time.
module lsx_ls_unit
    import lsx_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [31:0]      instr,
    input  logic [XLEN-1:0]  base_val,
    input  logic [XLEN-1:0]  ofs_val,
    input  logic [15:0]      store_half,
    output logic             mem_req_valid,
    output logic [XLEN-1:0]  mem_addr,
    output logic             mem_we,
    output logic             mem_size,
    output logic [15:0]      mem_wdata,
    input  logic             mem_rsp_valid,
    input  logic [15:0]      mem_rdata,
    input  logic             mem_fault,
    output logic             rd_we,
    output logic [IDX_W-1:0] rd_idx,
    output logic [XLEN-1:0]  rd_data,
    output logic             wb_we,
    output logic [IDX_W-1:0] wb_idx,
    output logic [XLEN-1:0]  wb_data,
    output logic             abort
);
    dec_t            dec;
    xfer_e           kind_q;
    logic [XLEN-1:0] addr_c;
    logic [XLEN-1:0] sum_c;
    logic [XLEN-1:0] ext_c;

    lsx_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    lsx_addr_gen #(.XLEN(XLEN), .IMM_W(8)) u_agen (
        .base    (base_val),
        .reg_ofs (ofs_val),
        .imm_ofs (dec.imm_ofs),
        .use_imm (dec.imm),
        .up      (dec.up),
        .pre     (dec.pre),
        .addr    (addr_c),
        .sum     (sum_c)
    );

    lsx_extend #(.XLEN(XLEN)) u_ext (
        .kind (kind_q),
        .raw  (mem_rdata),
        .ext  (ext_c)
    );

    lsx_ctrl #(.XLEN(XLEN), .IDX_W(IDX_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .dec           (dec),
        .addr_in       (addr_c),
        .sum_in        (sum_c),
        .wdata_in      (store_half),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_fault     (mem_fault),
        .ext_data      (ext_c),
        .kind_q        (kind_q),
        .mem_req_valid (mem_req_valid),
        .mem_addr      (mem_addr),
        .mem_we        (mem_we),
        .mem_size      (mem_size),
        .mem_wdata     (mem_wdata),
        .rd_we         (rd_we),
        .rd_idx        (rd_idx),
        .rd_data       (rd_data),
        .wb_we         (wb_we),
        .wb_idx        (wb_idx),
        .wb_data       (wb_data),
        .abort         (abort)
    );
endmodule

// File: rtl/lsx_checker.sv
// Property checker for lsx_ls_unit, attached by bind below.
module lsx_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [31:0]     instr,
    input logic [XLEN-1:0] base_val,
    input logic [XLEN-1:0] ofs_val,
    input logic            mem_req_valid,
    input logic [XLEN-1:0] mem_addr,
    input logic            mem_we,
    input logic            mem_size,
    input logic            mem_rsp_valid,
    input logic            mem_fault,
    input logic            rd_we,
    input logic            wb_we,
    input logic            abort
);
    AST_FAULT_NO_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_rsp_valid && mem_fault) |-> (!rd_we && !wb_we && abort)); // R8
    AST_ABORT_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (mem_req_valid && mem_rsp_valid && mem_fault)); // R8
    AST_STORE_NO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !rd_we); // R9
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=>
        (mem_req_valid && $stable(mem_addr) && $stable(mem_size) && $stable(mem_we))); // R10
    AST_IDLE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_rsp_valid) |=> !mem_req_valid); // R10
    AST_POST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mem_req_valid && !instr[24]) |=> (mem_addr == $past(base_val))); // R4
    AST_PRE_REG_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mem_req_valid && instr[24] && instr[23] && !instr[22]) |=>
        (mem_addr == $past(base_val) + $past(ofs_val))); // R5
    AST_WRITES_NEED_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_we || wb_we) |-> (mem_rsp_valid && !mem_fault)); // R10
endmodule

bind lsx_ls_unit lsx_checker #(.XLEN(XLEN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .instr         (instr),
    .base_val      (base_val),
    .ofs_val       (ofs_val),
    .mem_req_valid (mem_req_valid),
    .mem_addr      (mem_addr),
    .mem_we        (mem_we),
    .mem_size      (mem_size),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_fault     (mem_fault),
    .rd_we         (rd_we),
    .wb_we         (wb_we),
    .abort         (abort)
);

// File: tb/tb_lsx_ls_unit.sv
`timescale 1ns/1ps
module tb_lsx_ls_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] base_val = '0;
    logic [31:0] ofs_val = '0;
    logic [15:0] store_half = '0;
    logic        mem_req_valid;
    logic [31:0] mem_addr;
    logic        mem_we;
    logic        mem_size;
    logic [15:0] mem_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        mem_fault = 1'b0;
    logic        rd_we;
    logic [3:0]  rd_idx;
    logic [31:0] rd_data;
    logic        wb_we;
    logic [3:0]  wb_idx;
    logic [31:0] wb_data;
    logic        abort;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lsx_ls_unit dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit p, input bit u, input bit i, input bit w,
                                       input bit l, input logic [3:0] rn, input logic [3:0] rd,
                                       input logic [3:0] hi, input logic [3:0] code,
                                       input logic [3:0] lo);
        return {7'b0, p, u, i, w, l, rn, rd, hi, code, lo};
    endfunction

    // one operation; stall = cycles before response; junk = drive req_valid during stall
    task automatic run_op(input string tag, input logic [31:0] ins, input logic [31:0] b,
                          input logic [31:0] o, input logic [15:0] sd, input logic [15:0] rdat,
                          input bit flt, input int stall, input bit junk);
        logic [31:0] ofs, sum, addr, ext;
        bit wbe, ld;
        ofs  = ins[22] ? {24'b0, ins[11:8], ins[3:0]} : o;
        sum  = ins[23] ? b + ofs : b - ofs;
        addr = ins[24] ? sum : b;
        wbe  = !ins[24] || ins[21];
        ld   = ins[20];
        case (ins[7:4])
            4'b1101: ext = {{24{rdat[7]}}, rdat[7:0]};
            4'b1111: ext = {{16{rdat[15]}}, rdat};
            default: ext = {16'b0, rdat};
        endcase
        @(negedge clk);
        instr = ins; base_val = b; ofs_val = o; store_half = sd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = junk;
        instr = ~ins; base_val = ~b;
        #1;
        chk({tag, " R10 req raised"}, {31'b0, mem_req_valid}, 32'd1);
        chk({tag, " address"}, mem_addr, addr);
        chk({tag, " R1 size"}, {31'b0, mem_size}, {31'b0, ins[7:4] != 4'b1101});
        chk({tag, " R9 direction"}, {31'b0, mem_we}, {31'b0, !ld});
        if (!ld) chk({tag, " R9 store data"}, {16'b0, mem_wdata}, {16'b0, sd});
        for (int k = 0; k < stall; k++) begin
            @(negedge clk); #1;
            chk({tag, " R11 addr held during stall"}, mem_addr, addr);
            chk({tag, " R10 req held"}, {31'b0, mem_req_valid}, 32'd1);
        end
        mem_rsp_valid = 1'b1; mem_rdata = rdat; mem_fault = flt;
        #1;
        chk({tag, " R8 abort"}, {31'b0, abort}, {31'b0, flt});
        chk({tag, " R7 rd_we"}, {31'b0, rd_we}, {31'b0, ld && !flt});
        chk({tag, " wb_we"}, {31'b0, wb_we}, {31'b0, wbe && !flt});
        if (ld && !flt) begin
            chk({tag, " R7 rd_data"}, rd_data, ext);
            chk({tag, " R7 rd_idx"}, {28'b0, rd_idx}, {28'b0, ins[15:12]});
        end
        if (wbe && !flt) begin
            chk({tag, " wb_data"}, wb_data, sum);
            chk({tag, " R7 wb_idx"}, {28'b0, wb_idx}, {28'b0, ins[19:16]});
        end
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_fault = 1'b0; req_valid = 1'b0;
        #1;
        chk({tag, " R10/R11 idle after response"}, {31'b0, mem_req_valid}, 32'd0);
        chk({tag, " R8 abort one cycle"}, {31'b0, abort}, 32'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R12 req after reset", {31'b0, mem_req_valid}, 32'd0);
        chk("R12 writes after reset", {30'b0, rd_we, wb_we}, 32'd0);
        chk("R12 abort after reset", {31'b0, abort}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_imm_post_sbyte();   // R2 R4: W bit clear yet writeback happens
        run_op("R2/R4 imm post sbyte", mk(0,1,1,0,1, 4'd3, 4'd5, 4'hA, 4'b1101, 4'h6),
               32'h0000_1000, 32'hDEAD_BEEF, 16'h0, 16'h1285, 1'b0, 0, 1'b0);
    endtask
    task automatic t_imm_pre_sub_uhalf(); // R5 R6
        run_op("R5/R6 imm pre sub uhalf", mk(1,0,1,1,1, 4'd1, 4'd2, 4'h1, 4'b1011, 4'h4),
               32'h0000_0100, 32'h0, 16'h0, 16'h8001, 1'b0, 0, 1'b0);
    endtask
    task automatic t_imm_pre_nowb_shalf(); // R5 no writeback
        run_op("R5 pre no writeback shalf", mk(1,1,1,0,1, 4'd7, 4'd8, 4'h0, 4'b1111, 4'h2),
               32'h0000_2000, 32'h0, 16'h0, 16'h8001, 1'b0, 0, 1'b0);
    endtask
    task automatic t_reg_post_hi_ignored(); // R3 full register, hi nibble ignored
        run_op("R3 reg post sub hi ignored", mk(0,0,0,1,1, 4'd9, 4'd10, 4'hF, 4'b1101, 4'h4),
               32'h0010_0000, 32'h0001_2345, 16'h0, 16'hFF7F, 1'b0, 0, 1'b0);
    endtask
    task automatic t_reg_pre_wrap();      // R6 modulo wrap
        run_op("R6 reg pre add wrap", mk(1,1,0,1,1, 4'd4, 4'd6, 4'h0, 4'b1111, 4'h0),
               32'hFFFF_FFF0, 32'h0000_0020, 16'h0, 16'h7FFF, 1'b0, 0, 1'b0);
    endtask
    task automatic t_fault();             // R8
        run_op("R8 faulting load", mk(1,1,1,1,1, 4'd2, 4'd3, 4'h0, 4'b1011, 4'h8),
               32'h0000_3000, 32'h0, 16'h0, 16'h1234, 1'b1, 0, 1'b0);
    endtask
    task automatic t_store_half();        // R9
        run_op("R9 store half pre wb", mk(1,1,1,1,0, 4'd5, 4'd6, 4'h0, 4'b1011, 4'h2),
               32'h0000_4000, 32'h0, 16'hBEEF, 16'h0, 1'b0, 0, 1'b0);
    endtask
    task automatic t_store_byte_post();   // R9 R1 byte size
        run_op("R9 store byte post", mk(0,0,0,0,0, 4'd11, 4'd12, 4'h0, 4'b1101, 4'h0),
               32'h0000_5000, 32'h0000_0010, 16'h00AB, 16'h0, 1'b0, 0, 1'b0);
    endtask
    task automatic t_stall_ignore();      // R11 R10
        run_op("R11 stall with req held", mk(1,1,1,1,1, 4'd13, 4'd14, 4'h2, 4'b1011, 4'h0),
               32'h0000_6000, 32'h0, 16'h0, 16'h00C3, 1'b0, 3, 1'b1);
    endtask

    initial begin
        t_reset();
        t_imm_post_sbyte();
        t_imm_pre_sub_uhalf();
        t_imm_pre_nowb_shalf();
        t_reg_post_hi_ignored();
        t_reg_pre_wrap();
        t_fault();
        t_store_half();
        t_store_byte_post();
        t_stall_ignore();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule